// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading translation tables from memory. A walk starts at a slot in a context table. The slot's address comes from a table-pointer setting and the current context number. The walk then follows table descriptors through up to three levels until it reaches a page entry. A page entry at the first, second or third level maps a 16 MB, 256 KB or 4 KB page.

A request gives the address, an access kind (load, store or fetch) and a supervisor flag. The block then runs the walk over a single-word memory port that uses a request/valid handshake. It checks the permission field of the page entry against the access. When the page entry's referenced or modified bit has to change, the block writes the entry back. It returns a physical address, a page-size code and a fault code. Each fault is also recorded in a fault status register and a fault address register. The block runs one walk at a time. While a walk is in progress `busy` is high, and any new request is ignored.

When translation is switched off, the address passes straight through. If boot mode is also on, instruction fetches are steered into a boot ROM window.

Top module: `walk_unit`

## Requirements
- R1: After reset, `busy`, `rspValid`, `memReq`, `fsrOut` and `farOut` are all zero.
- R2: With `cfgEnable` low, a request completes without any memory access. It returns `rspPa` equal to `reqVa`, `rspSize` 0 and `rspFault` 0.
- R3: With `cfgEnable` low and `cfgBoot` high, a fetch (`reqKind`=2) returns `cfgPromBase | reqVa[18:0]`. Loads and stores still pass through unchanged.
- R4: The first read is at `(cfgCtxBase<<4) + (cfgCtxNum<<2)`. The low 2 bits of each entry read give its type: 0 invalid, 1 table descriptor, 2 page entry, 3 reserved. A descriptor gives the next address as `((entry & ~3)<<4) + 4*index`. The index is VA[31:24] at level 1, VA[23:18] at level 2 and VA[17:12] at level 3.
- R5: A page entry at level 1, 2 or 3 gives `rspSize` 2, 1 or 0. The physical address is `entry[27:8]<<12` plus VA[23:0], VA[17:0] or VA[11:0] respectively.
- R6: `rspFault` is `(level<<8)|4` for an invalid entry. It is `(level<<8)|16` for a reserved entry, for a page entry in the context slot, or for a descriptor at level 3. The context slot is level 0. On any fault, `rspPa` is 0.
- R7: Entry bits [4:2] give the permission field. Its values 0..7 grant read, read/write, read/exec, read/write/exec, exec only, read (supervisor adds write), none (supervisor read/exec), and none (supervisor all). A user access to a field of 6 or 7 faults with code 12. Any other access the field does not grant faults with code 8. `reqKind` 1 is a store, 2 is a fetch, and 0 or 3 is a load.
- R8: When `cfgNoFault` is high, a permission fault on a user access is dropped and the walk completes normally. Supervisor accesses still fault.
- R9: On a successful walk, the entry is written back to its own address if bit 5 (referenced) is clear, or if the access is a store and bit 6 (modified) is clear. The written value sets bit 5, and also bit 6 for a store. Otherwise no write takes place.
- R10: On a fault, a nonzero `fsrOut` is first replaced by 1. Then `(access_index<<5) | fault_code | 2` is ORed in, where access_index = {store, fetch, supervisor}. `farOut` is loaded with the VA with bits [11:0] cleared.
- R11: A cycle with `fsrRead` high clears `fsrOut` to zero at the next edge, unless a fault is being logged in that same cycle.
- R12: `busy` is high from the accepting edge to the end of the one-cycle `rspValid` pulse, and requests made while it is high are ignored. `memReq` stays high until `memValid` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgEnable | input | 1 | Translation enable |
| cfgBoot | input | 1 | Boot mode: fetches go to ROM window when translation is off |
| cfgNoFault | input | 1 | Drop permission faults on user accesses |
| cfgCtxBase | input | 32 | Context table pointer (shifted left 4 to form an address) |
| cfgCtxNum | input | CTX_W | Current context number |
| cfgPromBase | input | 32 | Boot ROM window base |
| reqValid | input | 1 | Translation request |
| reqVa | input | 32 | Virtual address |
| reqKind | input | 2 | 0 load, 1 store, 2 fetch, 3 load |
| reqSuper | input | 1 | Supervisor access |
| busy | output | 1 | Walk in progress |
| rspValid | output | 1 | One-cycle result strobe |
| rspPa | output | 32 | Physical address |
| rspSize | output | 2 | 0: 4 KB, 1: 256 KB, 2: 16 MB |
| rspFault | output | 10 | Fault code, 0 on success |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Memory access is a write |
| memAddr | output | 32 | Byte address of the word |
| memWdata | output | 32 | Write data |
| memValid | input | 1 | Memory access completes this cycle |
| memRdata | input | 32 | Read data, valid with memValid |
| fsrRead | input | 1 | Read of the fault status register (clears it) |
| fsrOut | output | 10 | Fault status register |
| farOut | output | 32 | Fault address register |

## Verification
The bench goes after the type decode at each level. A page entry in the context slot or a descriptor at level 3 must be reported as a translation error at the right level. A walker that loops one level too far, or that takes them as valid, would return an address or the wrong level code. It checks the permission field across all three access kinds and both privilege levels, including the write that supervisors gain on field 5 and the user-only effect of the no-fault bit. It counts write-backs, so a spurious write or a missing referenced/modified update shows up. It also exercises the overflow collapse of the fault status register, read clearing, and requests raised mid-walk that a design without a busy interlock would start.

// File: rtl/walk_pkg.sv
package walk_pkg;
  localparam int ADDR_W = 32;
  localparam int CODE_W = 10;
  localparam int FSR_W  = 10;

  localparam logic [1:0] KIND_STORE = 2'd1;
  localparam logic [1:0] KIND_FETCH = 2'd2;

  localparam logic [1:0] ET_INVALID = 2'd0;
  localparam logic [1:0] ET_TABLE   = 2'd1;
  localparam logic [1:0] ET_PAGE    = 2'd2;
  localparam logic [1:0] ET_RSVD    = 2'd3;

  localparam logic [1:0] SZ_4K   = 2'd0;
  localparam logic [1:0] SZ_256K = 2'd1;
  localparam logic [1:0] SZ_16M  = 2'd2;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_WRITE, ST_DONE} walkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic takeRead;
    logic logResult;
  } walkCmd_t;

  // decisions from datapath to control
  typedef struct packed {
    logic descend;
    logic needWrite;
  } walkStat_t;
endpackage

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import walk_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      cfgEnable,
  input  logic      memValid,
  input  walkStat_t stat,
  output walkCmd_t  cmd,
  output logic      busy,
  output logic      memReq,
  output logic      memWe,
  output logic      rspValid
);
  walkState_t state, stateNext;

  always_comb begin
    stateNext = state;
    cmd       = '0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    rspValid  = 1'b0;
    case (state)
      ST_IDLE: if (reqValid) begin
        cmd.capture = 1'b1;
        stateNext   = cfgEnable ? ST_FETCH : ST_DONE;
      end
      ST_FETCH: begin
        memReq = 1'b1;
        if (memValid) begin
          cmd.takeRead = 1'b1;
          if (stat.descend)        stateNext = ST_FETCH;
          else if (stat.needWrite) stateNext = ST_WRITE;
          else                     stateNext = ST_DONE;
        end
      end
      ST_WRITE: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memValid) stateNext = ST_DONE;
      end
      default: begin
        rspValid      = 1'b1;
        cmd.logResult = 1'b1;
        stateNext     = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state != ST_IDLE);

  // R12
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memValid |=> memReq);
  // R12
  resp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);
  // R12
  accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !busy |=> busy);
endmodule

// File: rtl/walk_dp.sv
module walk_dp
  import walk_pkg::*;
#(
  parameter int CTX_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkCmd_t          cmd,
  input  logic              cfgBoot,
  input  logic              cfgNoFault,
  input  logic [ADDR_W-1:0] cfgCtxBase,
  input  logic [CTX_W-1:0]  cfgCtxNum,
  input  logic [ADDR_W-1:0] cfgPromBase,
  input  logic [ADDR_W-1:0] reqVa,
  input  logic [1:0]        reqKind,
  input  logic              reqSuper,
  input  logic [31:0]       memRdata,
  input  logic              fsrRead,
  output walkStat_t         stat,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic [ADDR_W-1:0] rspPa,
  output logic [1:0]        rspSize,
  output logic [CODE_W-1:0] rspFault,
  output logic [FSR_W-1:0]  fsrOut,
  output logic [ADDR_W-1:0] farOut
);
  localparam int PAD_W = ADDR_W - CTX_W;

  logic [ADDR_W-1:0] vaReg, ptrReg, paReg, farReg;
  logic [31:0]       entryReg;
  logic              isStore, isFetch, isSuper;
  logic [1:0]        lvl, sizeReg;
  logic [CODE_W-1:0] codeReg;
  logic [FSR_W-1:0]  fsrReg;

  // entry decode at the current level
  logic [1:0] etype;
  logic       atLast, transErr, isPage, canR, canW, canX, needOk, permHit, walkOk;
  logic [2:0] acc;
  logic [CODE_W-1:0] permCode, walkCode;
  logic [ADDR_W-1:0] pageBase, pageOff, nextIdx, nextPtr, firstPtr, bypassPa;
  logic [1:0]  pageSize;
  logic [31:0] newEntry;

  assign etype    = memRdata[1:0];
  assign atLast   = (lvl == 2'd3);
  assign acc      = memRdata[4:2];
  assign transErr = (etype == ET_RSVD) || (etype == ET_PAGE && lvl == 2'd0) ||
                    (etype == ET_TABLE && atLast);
  assign isPage   = (etype == ET_PAGE) && (lvl != 2'd0);

  always_comb begin
    canR = 1'b0; canW = 1'b0; canX = 1'b0;
    case (acc)
      3'd0: canR = 1'b1;
      3'd1: begin canR = 1'b1; canW = 1'b1; end
      3'd2: begin canR = 1'b1; canX = 1'b1; end
      3'd3: begin canR = 1'b1; canW = 1'b1; canX = 1'b1; end
      3'd4: canX = 1'b1;
      3'd5: begin canR = 1'b1; canW = isSuper; end
      3'd6: begin canR = isSuper; canX = isSuper; end
      default: begin canR = isSuper; canW = isSuper; canX = isSuper; end
    endcase
  end

  assign needOk   = isStore ? canW : (isFetch ? canX : canR);
  assign permCode = (!isSuper && acc[2:1] == 2'b11) ? 10'd12 :
                    (!needOk ? 10'd8 : 10'd0);
  assign permHit  = (permCode != '0) && !(cfgNoFault && !isSuper);
  assign walkOk   = isPage && !permHit;

  always_comb begin
    if (etype == ET_INVALID)  walkCode = {lvl, 8'h04};
    else if (transErr)        walkCode = {lvl, 8'h10};
    else if (isPage && permHit) walkCode = permCode;
    else                      walkCode = '0;
  end

  always_comb begin
    case (lvl)
      2'd1:    begin pageOff = {8'b0, vaReg[23:0]};  pageSize = SZ_16M;  end
      2'd2:    begin pageOff = {14'b0, vaReg[17:0]}; pageSize = SZ_256K; end
      default: begin pageOff = {20'b0, vaReg[11:0]}; pageSize = SZ_4K;   end
    endcase
    case (lvl)
      2'd0:    nextIdx = {22'b0, vaReg[31:24], 2'b00};
      2'd1:    nextIdx = {24'b0, vaReg[23:18], 2'b00};
      default: nextIdx = {24'b0, vaReg[17:12], 2'b00};
    endcase
  end

  assign pageBase = {memRdata[27:8], 12'b0};
  assign nextPtr  = {memRdata[27:2], 6'b0} + nextIdx;
  assign firstPtr = (cfgCtxBase << 4) + ({{PAD_W{1'b0}}, cfgCtxNum} << 2);
  assign bypassPa = (reqKind == KIND_FETCH && cfgBoot) ?
                    (cfgPromBase | {13'b0, reqVa[18:0]}) : reqVa;
  assign newEntry = memRdata | 32'h20 | (isStore ? 32'h40 : 32'h0);

  assign stat.descend   = (etype == ET_TABLE) && !atLast;
  assign stat.needWrite = walkOk && (!memRdata[5] || (isStore && !memRdata[6]));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaReg <= '0; ptrReg <= '0; paReg <= '0; entryReg <= '0;
      isStore <= 1'b0; isFetch <= 1'b0; isSuper <= 1'b0;
      lvl <= '0; sizeReg <= SZ_4K; codeReg <= '0;
    end else if (cmd.capture) begin
      vaReg   <= reqVa;
      isStore <= (reqKind == KIND_STORE);
      isFetch <= (reqKind == KIND_FETCH);
      isSuper <= reqSuper;
      lvl     <= 2'd0;
      ptrReg  <= firstPtr;
      paReg   <= bypassPa;
      sizeReg <= SZ_4K;
      codeReg <= '0;
    end else if (cmd.takeRead) begin
      if (stat.descend) begin
        lvl    <= lvl + 2'd1;
        ptrReg <= nextPtr;
      end else begin
        entryReg <= newEntry;
        codeReg  <= walkCode;
        paReg    <= walkOk ? (pageBase + pageOff) : '0;
        sizeReg  <= walkOk ? pageSize : SZ_4K;
      end
    end
  end

  // fault status and address registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fsrReg <= '0;
      farReg <= '0;
    end else if (cmd.logResult && codeReg != '0) begin
      fsrReg <= {{(FSR_W-1){1'b0}}, (fsrReg != '0)} |
                {2'b0, isStore, isFetch, isSuper, 5'b0} | codeReg | 10'd2;
      farReg <= {vaReg[31:12], 12'b0};
    end else if (fsrRead) begin
      fsrReg <= '0;
    end
  end

  assign memAddr  = ptrReg;
  assign memWdata = entryReg;
  assign rspPa    = paReg;
  assign rspSize  = sizeReg;
  assign rspFault = codeReg;
  assign fsrOut   = fsrReg;
  assign farOut   = farReg;

  // R6
  fault_pa_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.logResult && rspFault != '0 |-> rspPa == '0);
  // R10
  fsr_log_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.logResult && rspFault != '0 |=> fsrOut[1]);
  // R11
  fsr_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    fsrRead && !cmd.logResult |=> fsrOut == '0);
endmodule

// File: rtl/walk_unit.sv
module walk_unit
  import walk_pkg::*;
#(
  parameter int CTX_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgEnable,
  input  logic              cfgBoot,
  input  logic              cfgNoFault,
  input  logic [ADDR_W-1:0] cfgCtxBase,
  input  logic [CTX_W-1:0]  cfgCtxNum,
  input  logic [ADDR_W-1:0] cfgPromBase,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqVa,
  input  logic [1:0]        reqKind,
  input  logic              reqSuper,
  output logic              busy,
  output logic              rspValid,
  output logic [ADDR_W-1:0] rspPa,
  output logic [1:0]        rspSize,
  output logic [CODE_W-1:0] rspFault,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic              memValid,
  input  logic [31:0]       memRdata,
  input  logic              fsrRead,
  output logic [FSR_W-1:0]  fsrOut,
  output logic [ADDR_W-1:0] farOut
);
  walkCmd_t  cmd;
  walkStat_t stat;

  walk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .cfgEnable(cfgEnable),
    .memValid(memValid), .stat(stat), .cmd(cmd), .busy(busy),
    .memReq(memReq), .memWe(memWe), .rspValid(rspValid)
  );

  walk_dp #(.CTX_W(CTX_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .cfgBoot(cfgBoot),
    .cfgNoFault(cfgNoFault), .cfgCtxBase(cfgCtxBase), .cfgCtxNum(cfgCtxNum),
    .cfgPromBase(cfgPromBase), .reqVa(reqVa), .reqKind(reqKind),
    .reqSuper(reqSuper), .memRdata(memRdata), .fsrRead(fsrRead),
    .stat(stat), .memAddr(memAddr), .memWdata(memWdata), .rspPa(rspPa),
    .rspSize(rspSize), .rspFault(rspFault), .fsrOut(fsrOut), .farOut(farOut)
  );
endmodule

// File: tb/walk_unit_bench.sv
module walk_unit_bench;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgEnable = 1'b0, cfgBoot = 1'b0, cfgNoFault = 1'b0;
  logic [31:0] cfgCtxBase = 32'h40, cfgPromBase = 32'hF000_0000;
  logic [7:0]  cfgCtxNum = 8'd2;
  logic reqValid = 1'b0, reqSuper = 1'b0, fsrRead = 1'b0;
  logic [31:0] reqVa = '0;
  logic [1:0]  reqKind = '0;
  logic busy, rspValid, memReq, memWe;
  logic [31:0] rspPa, memAddr, memWdata, farOut;
  logic [1:0]  rspSize;
  logic [9:0]  rspFault, fsrOut;
  logic memValid = 1'b0;
  logic [31:0] memRdata;

  logic [31:0] mem [0:4095];
  int compared = 0, mismatched = 0, writeCount = 0, rspCount = 0;

  // model state for fault registers
  logic [9:0]  modelFsr = '0, expFc = '0, lastFault = '0;
  logic [31:0] modelFar = '0, expVa = '0;
  logic [1:0]  expKind = '0;
  logic        expSup = 1'b0;
  bit          trackOn = 0;

  always #(CLK_NS/2) clk = ~clk;

  walk_unit u_walk_unit (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgBoot(cfgBoot),
    .cfgNoFault(cfgNoFault), .cfgCtxBase(cfgCtxBase), .cfgCtxNum(cfgCtxNum),
    .cfgPromBase(cfgPromBase), .reqValid(reqValid), .reqVa(reqVa),
    .reqKind(reqKind), .reqSuper(reqSuper), .busy(busy), .rspValid(rspValid),
    .rspPa(rspPa), .rspSize(rspSize), .rspFault(rspFault), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata), .memValid(memValid),
    .memRdata(memRdata), .fsrRead(fsrRead), .fsrOut(fsrOut), .farOut(farOut)
  );

  // memory: one-cycle latency, valid for one cycle
  assign memRdata = mem[memAddr[13:2]];
  always @(posedge clk) begin
    if (!rstN) memValid <= 1'b0;
    else       memValid <= memReq && !memValid;
    if (memReq && memValid && memWe) begin
      mem[memAddr[13:2]] <= memWdata;
      writeCount <= writeCount + 1;
    end
    if (rspValid) rspCount <= rspCount + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // per-clock comparison of the fault registers (R10, R11)
  always @(negedge clk) begin
    if (rstN && trackOn) begin
      check(fsrOut == modelFsr, "R10/R11", "fsrOut", 32'(fsrOut), 32'(modelFsr));
      check(farOut == modelFar, "R10", "farOut", farOut, modelFar);
      if (rspValid && expFc != '0) begin
        modelFsr = ((modelFsr != '0) ? 10'd1 : 10'd0) |
                   {2'b0, expKind == 2'd1, expKind == 2'd2, expSup, 5'b0} |
                   expFc | 10'd2;
        modelFar = {expVa[31:12], 12'b0};
      end else if (fsrRead) begin
        modelFsr = '0;
      end
    end
  end

  // behavioural reference of one translation
  function automatic void refWalk(input logic [31:0] va, input logic [1:0] kind,
      input logic sup, output logic [31:0] pa, output logic [1:0] sz,
      output logic [9:0] fc, output bit wr, output logic [31:0] wAddr,
      output logic [31:0] wData);
    logic [31:0] ptr, e, idx, mask;
    logic [2:0] a;
    bit r, w, x, need;
    int code;
    pa = '0; sz = '0; fc = '0; wr = 0; wAddr = '0; wData = '0;
    if (!cfgEnable) begin
      pa = (kind == 2'd2 && cfgBoot) ? (cfgPromBase | (va & 32'h7FFFF)) : va;
      return;
    end
    ptr = (cfgCtxBase << 4) + ({24'b0, cfgCtxNum} << 2);
    for (int lv = 0; lv < 4; lv++) begin
      e = mem[ptr[13:2]];
      if (e[1:0] == 2'd0) begin fc = 10'(lv * 256 + 4); return; end
      if (e[1:0] == 2'd3) begin fc = 10'(lv * 256 + 16); return; end
      if (e[1:0] == 2'd1) begin
        if (lv == 3) begin fc = 10'(lv * 256 + 16); return; end
        if (lv == 0)      idx = va >> 24;
        else if (lv == 1) idx = (va >> 18) & 32'h3F;
        else              idx = (va >> 12) & 32'h3F;
        ptr = ((e & ~32'h3) << 4) + idx * 4;
        continue;
      end
      if (lv == 0) begin fc = 10'd16; return; end
      a = e[4:2];
      r = (a != 3'd4) && (a < 3'd6 || sup);
      w = (a == 3'd1 || a == 3'd3) || (sup && (a == 3'd5 || a == 3'd7));
      x = (a == 3'd2 || a == 3'd3 || a == 3'd4) || (sup && a >= 3'd6);
      need = (kind == 2'd1) ? w : ((kind == 2'd2) ? x : r);
      code = (!sup && a >= 3'd6) ? 12 : (!need ? 8 : 0);
      if (code != 0 && !(cfgNoFault && !sup)) begin fc = 10'(code); return; end
      mask = (lv == 1) ? 32'hFFFFFF : ((lv == 2) ? 32'h3FFFF : 32'hFFF);
      pa = (((e >> 8) & 32'hFFFFF) << 12) + (va & mask);
      sz = 2'(3 - lv);
      if (!e[5] || (kind == 2'd1 && !e[6])) begin
        wr = 1; wAddr = ptr;
        wData = e | 32'h20 | ((kind == 2'd1) ? 32'h40 : 32'h0);
      end
      return;
    end
  endfunction

  task automatic doWalk(input logic [31:0] va, input logic [1:0] kind,
                        input logic sup, input string req);
    logic [31:0] ePa, wA, wD;
    logic [1:0]  eSz;
    logic [9:0]  eFc;
    bit eWr;
    int w0;
    refWalk(va, kind, sup, ePa, eSz, eFc, eWr, wA, wD);
    expVa = va; expKind = kind; expSup = sup; expFc = eFc;
    w0 = writeCount;
    @(posedge clk); #2;
    reqValid = 1'b1; reqVa = va; reqKind = kind; reqSuper = sup;
    @(posedge clk); #2;
    reqValid = 1'b0;
    check(busy == 1'b1, "R12", "busy after accept", 32'(busy), 32'd1);
    do @(negedge clk); while (!rspValid);
    lastFault = rspFault;
    check(rspPa == ePa, req, "rspPa", rspPa, ePa);
    check(rspSize == eSz, req, "rspSize", 32'(rspSize), 32'(eSz));
    check(rspFault == eFc, req, "rspFault", 32'(rspFault), 32'(eFc));
    @(posedge clk); #2;
    check(busy == 1'b0, "R12", "busy after response", 32'(busy), 32'd0);
    check((writeCount - w0) == int'(eWr), "R9", "write-back count",
          32'(writeCount - w0), 32'(eWr));
    if (eWr) check(mem[wA[13:2]] == wD, "R9", "written entry", mem[wA[13:2]], wD);
  endtask

  task automatic readFsr();
    @(posedge clk); #2; fsrRead = 1'b1;
    @(posedge clk); #2; fsrRead = 1'b0;
  endtask

  function automatic logic [31:0] pte(input logic [19:0] ppn, input logic m,
                                      input logic r, input logic [2:0] a);
    return {4'b0, ppn, 1'b0, m, r, a, 2'b10};
  endfunction

  task automatic setW(input logic [31:0] addr, input logic [31:0] val);
    mem[addr[13:2]] = val;
  endtask

  initial begin
    #(CLK_NS * 200000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    // R4 table layout: context table 0x400, L1 0x800, L2 0xC00, L3 0xD00
    setW(32'h408, 32'h81);
    setW(32'h40C, 32'h102);                 // page entry in a context slot
    setW(32'h800 + 4*32'h12, 32'hC1);
    setW(32'h800 + 4*32'h20, pte(20'h00ABC, 1'b1, 1'b1, 3'd1));
    setW(32'h800 + 4*32'h31, 32'h3);
    setW(32'hC00 + 4*13,     32'hD1);
    setW(32'hC00 + 4*32'h10, pte(20'h01230, 1'b0, 1'b0, 3'd2));
    setW(32'hC00 + 4*32'h21, 32'h3);
    setW(32'hD00 + 4*5,  pte(20'h05555, 1'b0, 1'b0, 3'd1));
    setW(32'hD00 + 4*7,  32'hD1);           // descriptor at the last level
    setW(32'hD00 + 4*8,  pte(20'h08888, 1'b0, 1'b1, 3'd5));
    setW(32'hD00 + 4*9,  pte(20'h09999, 1'b0, 1'b0, 3'd6));
    setW(32'hD00 + 4*10, pte(20'h0AAAA, 1'b1, 1'b1, 3'd4));

    repeat (4) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1", "busy", 32'(busy), 0);
    check(rspValid == 1'b0, "R1", "rspValid", 32'(rspValid), 0);
    check(memReq == 1'b0, "R1", "memReq", 32'(memReq), 0);
    check(fsrOut == '0, "R1", "fsrOut", 32'(fsrOut), 0);
    check(farOut == '0, "R1", "farOut", farOut, 0);
    trackOn = 1;

    // R2 / R3 translation off
    doWalk(32'h1234_5678, 2'd0, 1'b0, "R2");
    doWalk(32'hABCD_EF01, 2'd2, 1'b1, "R2");
    cfgBoot = 1'b1;
    doWalk(32'hABCD_EF01, 2'd2, 1'b0, "R3");
    doWalk(32'hABCD_EF01, 2'd1, 1'b0, "R3");
    cfgBoot = 1'b0;

    cfgEnable = 1'b1;
    // R4 R5 R9 level-3 page, referenced then modified
    doWalk(32'h1234_5678, 2'd0, 1'b0, "R5");
    doWalk(32'h1234_5678, 2'd1, 1'b0, "R9");
    doWalk(32'h1234_5ABC, 2'd1, 1'b0, "R9");
    doWalk(32'h1234_5ABC, 2'd3, 1'b1, "R7");
    // level-2 and level-1 pages
    doWalk(32'h1243_ABCD, 2'd2, 1'b1, "R5");
    doWalk(32'h20FE_DCBA, 2'd0, 1'b0, "R5");

    // R6 walk faults at every level
    cfgCtxNum = 8'd4;
    doWalk(32'h1234_5678, 2'd0, 1'b0, "R6");
    check(lastFault == 10'h004, "R6", "context invalid code", 32'(lastFault), 32'h004);
    cfgCtxNum = 8'd3;
    doWalk(32'h1234_5678, 2'd0, 1'b1, "R6");
    cfgCtxNum = 8'd2;
    readFsr();
    doWalk(32'h3000_0000, 2'd1, 1'b0, "R6");
    check(lastFault == 10'h104, "R6", "level-1 invalid code", 32'(lastFault), 32'h104);
    doWalk(32'h3100_0000, 2'd0, 1'b1, "R6");
    @(negedge clk);
    check(fsrOut[0] == 1'b1, "R10", "overflow mark", 32'(fsrOut[0]), 1);
    doWalk(32'h1280_0000, 2'd2, 1'b0, "R6");
    doWalk(32'h1284_0000, 2'd0, 1'b0, "R6");
    doWalk(32'h1234_6000, 2'd0, 1'b0, "R6");
    doWalk(32'h1234_7000, 2'd0, 1'b1, "R6");
    check(lastFault == 10'h310, "R6", "level-3 descriptor code", 32'(lastFault), 32'h310);
    readFsr();
    @(negedge clk);
    check(fsrOut == '0, "R11", "fsr cleared by read", 32'(fsrOut), 0);

    // R7 permission checks
    doWalk(32'h1234_8000, 2'd1, 1'b0, "R7");
    doWalk(32'h1234_8000, 2'd1, 1'b1, "R7");
    doWalk(32'h1234_9000, 2'd0, 1'b0, "R7");
    check(lastFault == 10'd12, "R7", "user on field 6", 32'(lastFault), 12);
    doWalk(32'h1234_9000, 2'd0, 1'b1, "R7");
    doWalk(32'h1234_A000, 2'd2, 1'b0, "R7");
    doWalk(32'h1234_A000, 2'd0, 1'b1, "R7");
    check(lastFault == 10'd8, "R7", "super load on exec-only", 32'(lastFault), 8);
    readFsr();

    // R8 no-fault mode
    cfgNoFault = 1'b1;
    doWalk(32'h1234_9000, 2'd1, 1'b0, "R8");
    doWalk(32'h1234_8000, 2'd1, 1'b0, "R8");
    doWalk(32'h1234_A000, 2'd0, 1'b1, "R8");
    cfgNoFault = 1'b0;

    // R12 request during a walk is ignored
    begin
      logic [31:0] ePa, wA, wD;
      logic [1:0] eSz;
      logic [9:0] eFc;
      bit eWr;
      int r0;
      refWalk(32'h1243_0010, 2'd0, 1'b0, ePa, eSz, eFc, eWr, wA, wD);
      expVa = 32'h1243_0010; expKind = 2'd0; expSup = 1'b0; expFc = eFc;
      r0 = rspCount;
      @(posedge clk); #2;
      reqValid = 1'b1; reqVa = 32'h1243_0010; reqKind = 2'd0; reqSuper = 1'b0;
      @(posedge clk); #2;
      reqVa = 32'h3000_0000;
      repeat (2) @(posedge clk);
      #2 reqValid = 1'b0;
      do @(negedge clk); while (!rspValid);
      check(rspPa == ePa, "R12", "first request result", rspPa, ePa);
      repeat (12) @(posedge clk);
      #2;
      check((rspCount - r0) == 1, "R12", "one response only", 32'(rspCount - r0), 1);
    end

    repeat (2) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule